// File: doc/BRIEF.md
# Flag-Mode Controller ALU

This block is the combinational arithmetic and logic unit of a small 8-bit controller. One call computes a result and a new pair of carry and zero flags from two operands, the current flags and a handful of operation fields. A two-bit group field selects one of four families:
- an operand pass-through (load),
- a one-position rotate or shift,
- a bitwise logic operation,
- an add or subtract, with or without the incoming carry.

A rotate or shift moves the operand one position in either direction. A separate source field decides which bit enters the vacated position, so one datapath covers every rotate, shift-in-constant, shift-in-carry, arithmetic-right and replicate-low-bit form. A two-bit carry mode then chooses whether the carry output is the group's own carry or a kept, cleared or set value.

The surrounding core owns the flag registers, the operand selection and any suppression of writeback. The ALU only presents the candidate values. It has no clock and no state, so every output follows its inputs within the same cycle.

Top module: `flagAlu`

## Requirements
- R1: With `opType` = 00 (load), `result` equals `opB`, `carryOut` equals `carryIn` and `zeroOut` equals `zeroIn`. All other fields, including `carryMode`, have no effect in this group.
- R2: With `opType` = 10 (logic), `result` is `opA & opB` for `logicSel` 00, `opA | opB` for 01, and `opA ^ opB` for 10 or 11. The group's own carry is 0.
- R3: With `opType` = 11 and `arithSub` = 0, `result` is the low 8 bits of `opA + opB + k`. Here k is `carryIn` when `arithUseCarry` = 1 and 0 otherwise. The group's own carry is bit 8 of that sum.
- R4: With `opType` = 11 and `arithSub` = 1, `result` is the low 8 bits of `opA - opB - k`, with k as in R3. The group's own carry is the borrow, which is 1 exactly when `opB + k` exceeds `opA`.
- R5: With `opType` = 01 and `shiftRight` = 0, `result` is `{opA[6:0], ins}` and the group's own carry is `opA[7]`.
- R6: With `opType` = 01 and `shiftRight` = 1, `result` is `{ins, opA[7:1]}` and the group's own carry is `opA[0]`.
- R7: The inserted bit `ins` is chosen by `insertSrc`:
  - 00: `insertConst`.
  - 01: `carryIn`.
  - 10: the bit leaving at the far end. This is `opA[7]` going left and `opA[0]` going right, which gives a rotate.
  - 11: the operand's own edge bit. This is `opA[0]` going left and `opA[7]` going right.
- R8: Outside the load group, `carryOut` is set by `carryMode`:
  - 00: the group's own carry.
  - 01: `carryIn`.
  - 10: 0.
  - 11: 1.
- R9: Outside the load group, `zeroOut` is 1 exactly when all 8 bits of `result` are 0.
- R10: With `arithUseCarry` = 0, `carryIn` has no effect on an add or subtract result or on its own carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opType | input | 2 | Group: 00 load, 01 rotate/shift, 10 logic, 11 arithmetic |
| arithSub | input | 1 | 0 add, 1 subtract |
| arithUseCarry | input | 1 | Include `carryIn` in add/subtract |
| logicSel | input | 2 | 00 AND, 01 OR, 10/11 XOR |
| shiftRight | input | 1 | 1 right, 0 left |
| insertSrc | input | 2 | Source of the inserted bit |
| insertConst | input | 1 | Inserted value when `insertSrc` = 00 |
| carryMode | input | 2 | Carry output mode |
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand |
| carryIn | input | 1 | Current carry flag |
| zeroIn | input | 1 | Current zero flag |
| result | output | 8 | Operation result |
| carryOut | output | 1 | New carry value |
| zeroOut | output | 1 | New zero value |

## Verification
There is no register between any input and any output, so each result, carry and zero value is due in the same cycle its inputs are applied. The bench therefore drives a new vector just after a rising edge and compares all three outputs at the following falling edge. At that point the inputs have been stable for half a period and no edge is near.

// File: rtl/flagAluPkg.sv
package flagAluPkg;

  // group selector codes
  localparam logic [1:0] GRP_LOAD  = 2'b00;
  localparam logic [1:0] GRP_SHIFT = 2'b01;
  localparam logic [1:0] GRP_LOGIC = 2'b10;
  localparam logic [1:0] GRP_ARITH = 2'b11;

  // insertion sources
  localparam logic [1:0] INS_CONST = 2'b00;
  localparam logic [1:0] INS_CARRY = 2'b01;
  localparam logic [1:0] INS_WRAP  = 2'b10;
  localparam logic [1:0] INS_EDGE  = 2'b11;

  // carry output modes
  localparam logic [1:0] CY_NATURAL = 2'b00;
  localparam logic [1:0] CY_KEEP    = 2'b01;
  localparam logic [1:0] CY_CLEAR   = 2'b10;
  localparam logic [1:0] CY_SET     = 2'b11;

  // strobes from control to datapath
  typedef struct packed {
    logic selLoad;
    logic selShift;
    logic selLogic;
    logic selArith;
    logic logAnd;
    logic logOr;
    logic logXor;
    logic sub;
    logic cinUsed;
    logic dirRight;
    logic insConst;
    logic insCarry;
    logic insWrap;
    logic insEdge;
    logic insConstVal;
    logic cyNatural;
    logic cyKeep;
    logic cySet;
  } aluStrobes_t;

endpackage

// File: rtl/flagAluCtrl.sv
module flagAluCtrl
  import flagAluPkg::*;
(
  input  logic [1:0]  opType,
  input  logic        arithSub,
  input  logic        arithUseCarry,
  input  logic [1:0]  logicSel,
  input  logic        shiftRight,
  input  logic [1:0]  insertSrc,
  input  logic        insertConst,
  input  logic [1:0]  carryMode,
  input  logic        carryIn,
  output aluStrobes_t strobes
);

  always_comb begin
    strobes             = '0;
    strobes.selLoad     = (opType == GRP_LOAD);
    strobes.selShift    = (opType == GRP_SHIFT);
    strobes.selLogic    = (opType == GRP_LOGIC);
    strobes.selArith    = (opType == GRP_ARITH);
    strobes.logAnd      = (logicSel == 2'b00);
    strobes.logOr       = (logicSel == 2'b01);
    strobes.logXor      = logicSel[1];
    strobes.sub         = arithSub;
    strobes.cinUsed     = arithUseCarry & carryIn;
    strobes.dirRight    = shiftRight;
    strobes.insConst    = (insertSrc == INS_CONST);
    strobes.insCarry    = (insertSrc == INS_CARRY);
    strobes.insWrap     = (insertSrc == INS_WRAP);
    strobes.insEdge     = (insertSrc == INS_EDGE);
    strobes.insConstVal = insertConst;
    strobes.cyNatural   = (carryMode == CY_NATURAL);
    strobes.cyKeep      = (carryMode == CY_KEEP);
    strobes.cySet       = (carryMode == CY_SET);
  end

endmodule

// File: rtl/flagAluPath.sv
module flagAluPath
  import flagAluPkg::*;
#(
  parameter int W = 8
) (
  input  aluStrobes_t   strobes,
  input  logic [W-1:0]  opA,
  input  logic [W-1:0]  opB,
  input  logic          carryIn,
  input  logic          zeroIn,
  output logic [W-1:0]  result,
  output logic          carryOut,
  output logic          zeroOut
);

  localparam int MSB = W - 1;

  logic [W:0]   addSum;
  logic [W:0]   subDiff;
  logic [W:0]   cinExt;
  logic         wrapBit;
  logic         edgeBit;
  logic         insBit;
  logic [W-1:0] shiftRes;
  logic         shiftCy;
  logic [W-1:0] logicRes;
  logic [W-1:0] arithRes;
  logic         arithCy;
  logic         naturalCy;
  logic [W-1:0] zeroVec;

  // arithmetic: one extra bit carries the carry or the borrow
  always_comb begin
    cinExt   = {{W{1'b0}}, strobes.cinUsed};
    addSum   = {1'b0, opA} + {1'b0, opB} + cinExt;
    subDiff  = {1'b0, opA} - {1'b0, opB} - cinExt;
    arithRes = strobes.sub ? subDiff[MSB:0] : addSum[MSB:0];
    arithCy  = strobes.sub ? subDiff[W] : addSum[W];
  end

  // rotate / shift by one with selectable inserted bit
  always_comb begin
    wrapBit = strobes.dirRight ? opA[0] : opA[MSB];
    edgeBit = strobes.dirRight ? opA[MSB] : opA[0];
    insBit  = (strobes.insConst & strobes.insConstVal)
            | (strobes.insCarry & carryIn)
            | (strobes.insWrap  & wrapBit)
            | (strobes.insEdge  & edgeBit);
    if (strobes.dirRight) begin
      shiftRes = {insBit, opA[MSB:1]};
      shiftCy  = opA[0];
    end else begin
      shiftRes = {opA[MSB-1:0], insBit};
      shiftCy  = opA[MSB];
    end
  end

  // bitwise logic
  always_comb begin
    logicRes = ({W{strobes.logAnd}} & (opA & opB))
             | ({W{strobes.logOr}}  & (opA | opB))
             | ({W{strobes.logXor}} & (opA ^ opB));
  end

  // result select (groups are one-hot)
  always_comb begin
    result = ({W{strobes.selLoad}}  & opB)
           | ({W{strobes.selShift}} & shiftRes)
           | ({W{strobes.selLogic}} & logicRes)
           | ({W{strobes.selArith}} & arithRes);
  end

  // zero detect, per-bit reduction chain
  assign zeroVec[0] = ~result[0];
  for (genvar i = 1; i < W; i++) begin : g_zero
    assign zeroVec[i] = zeroVec[i-1] & ~result[i];
  end

  // flag outputs
  always_comb begin
    naturalCy = (strobes.selShift & shiftCy) | (strobes.selArith & arithCy);
    if (strobes.selLoad) begin
      carryOut = carryIn;
      zeroOut  = zeroIn;
    end else begin
      if (strobes.cyNatural)   carryOut = naturalCy;
      else if (strobes.cyKeep) carryOut = carryIn;
      else                     carryOut = strobes.cySet;
      zeroOut = zeroVec[MSB];
    end
  end

endmodule

// File: rtl/flagAlu.sv
module flagAlu
  import flagAluPkg::*;
#(
  parameter int W = 8
) (
  input  logic [1:0]   opType,
  input  logic         arithSub,
  input  logic         arithUseCarry,
  input  logic [1:0]   logicSel,
  input  logic         shiftRight,
  input  logic [1:0]   insertSrc,
  input  logic         insertConst,
  input  logic [1:0]   carryMode,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         carryIn,
  input  logic         zeroIn,
  output logic [W-1:0] result,
  output logic         carryOut,
  output logic         zeroOut
);

  aluStrobes_t strobes;

  flagAluCtrl i_ctrl (
    .opType        (opType),
    .arithSub      (arithSub),
    .arithUseCarry (arithUseCarry),
    .logicSel      (logicSel),
    .shiftRight    (shiftRight),
    .insertSrc     (insertSrc),
    .insertConst   (insertConst),
    .carryMode     (carryMode),
    .carryIn       (carryIn),
    .strobes       (strobes)
  );

  flagAluPath #(.W(W)) i_path (
    .strobes  (strobes),
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .zeroIn   (zeroIn),
    .result   (result),
    .carryOut (carryOut),
    .zeroOut  (zeroOut)
  );

endmodule

// File: rtl/flagAluChk.sv
module flagAluChk #(
  parameter int W = 8
) (
  input logic [1:0]   opType,
  input logic         arithSub,
  input logic         arithUseCarry,
  input logic [1:0]   logicSel,
  input logic         shiftRight,
  input logic [1:0]   insertSrc,
  input logic         insertConst,
  input logic [1:0]   carryMode,
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic         carryIn,
  input logic         zeroIn,
  input logic [W-1:0] result,
  input logic         carryOut,
  input logic         zeroOut
);

  always_comb begin
    // R1
    load_pass_chk: assert (opType != 2'b00 ||
      (result == opB && carryOut == carryIn && zeroOut == zeroIn));
    // R9
    zero_flag_chk: assert (opType == 2'b00 || zeroOut == (result == '0));
    // R8
    carry_force_chk: assert (opType == 2'b00 || carryMode[1] == 1'b0 ||
      carryOut == carryMode[0]);
    // R8
    carry_keep_chk: assert (opType == 2'b00 || carryMode != 2'b01 ||
      carryOut == carryIn);
    // R2
    logic_carry_chk: assert (opType != 2'b10 || carryMode != 2'b00 ||
      carryOut == 1'b0);
    // R5
    shift_left_chk: assert (opType != 2'b01 || shiftRight ||
      (result[W-1:1] == opA[W-2:0] &&
       (carryMode != 2'b00 || carryOut == opA[W-1])));
    // R6
    shift_right_chk: assert (opType != 2'b01 || !shiftRight ||
      (result[W-2:0] == opA[W-1:1] &&
       (carryMode != 2'b00 || carryOut == opA[0])));
  end

endmodule

bind flagAlu flagAluChk #(.W(W)) i_chk (.*);

// File: tb/test_flagAlu.sv
module test_flagAlu;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] opType = '0;
  logic       arithSub = 1'b0;
  logic       arithUseCarry = 1'b0;
  logic [1:0] logicSel = '0;
  logic       shiftRight = 1'b0;
  logic [1:0] insertSrc = '0;
  logic       insertConst = 1'b0;
  logic [1:0] carryMode = '0;
  logic [7:0] opA = '0;
  logic [7:0] opB = '0;
  logic       carryIn = 1'b0;
  logic       zeroIn = 1'b0;
  logic [7:0] result;
  logic       carryOut;
  logic       zeroOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  flagAlu i_flagAlu (.*);

  // expected {carry, zero, result} from the requirements
  function automatic logic [9:0] expect_out();
    logic [8:0] wide;
    logic [7:0] r;
    logic       nat;
    logic       ins;
    logic       k;
    logic       c;
    k = arithUseCarry & carryIn;
    r = '0;
    nat = 1'b0;
    case (opType)
      2'b00: return {carryIn, zeroIn, opB};
      2'b01: begin
        case (insertSrc)
          2'b00: ins = insertConst;
          2'b01: ins = carryIn;
          2'b10: ins = shiftRight ? opA[0] : opA[7];
          default: ins = shiftRight ? opA[7] : opA[0];
        endcase
        if (shiftRight) begin r = {ins, opA[7:1]}; nat = opA[0]; end
        else            begin r = {opA[6:0], ins}; nat = opA[7]; end
      end
      2'b10: begin
        if (logicSel == 2'b00)      r = opA & opB;
        else if (logicSel == 2'b01) r = opA | opB;
        else                        r = opA ^ opB;
      end
      default: begin
        if (!arithSub) begin
          wide = 9'(opA) + 9'(opB) + 9'(k);
          r = wide[7:0]; nat = wide[8];
        end else begin
          wide = 9'(opA) - 9'(opB) - 9'(k);
          r = wide[7:0];
          nat = (9'(opB) + 9'(k)) > 9'(opA);
        end
      end
    endcase
    case (carryMode)
      2'b00: c = nat;
      2'b01: c = carryIn;
      2'b10: c = 1'b0;
      default: c = 1'b1;
    endcase
    return {c, (r == 8'h00), r};
  endfunction

  task automatic check(input string req);
    logic [9:0] exp;
    exp = expect_out();
    checks++;
    if ({carryOut, zeroOut, result} !== exp) begin
      errors++;
      $display("FAIL %s: got c=%0b z=%0b r=%02h, expected c=%0b z=%0b r=%02h",
               req, carryOut, zeroOut, result, exp[9], exp[8], exp[7:0]);
    end
  endtask

  task automatic apply(input logic [1:0] t, input logic s, input logic u,
                       input logic [1:0] ls, input logic d, input logic [1:0] is,
                       input logic ic, input logic [1:0] cm, input logic [7:0] a,
                       input logic [7:0] b, input logic ci, input logic zi,
                       input string req);
    @(posedge clk);
    opType = t; arithSub = s; arithUseCarry = u; logicSel = ls;
    shiftRight = d; insertSrc = is; insertConst = ic; carryMode = cm;
    opA = a; opB = b; carryIn = ci; zeroIn = zi;
    @(negedge clk);
    check(req);
  endtask

  function automatic string tag_of();
    if (carryMode != 2'b00 && opType != 2'b00) return "R8";
    case (opType)
      2'b00: return "R1";
      2'b01: return shiftRight ? "R6" : "R5";
      2'b10: return "R2";
      default: return arithSub ? "R4" : "R3";
    endcase
  endfunction

  initial begin
    #40000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-state check: all-zero inputs give a load of zero, flags held (R1)
    @(negedge clk);
    check("R1");

    // directed corners
    apply(2'b00, 0, 0, 2'b00, 0, 2'b00, 0, 2'b11, 8'h12, 8'hA5, 1, 0, "R1");
    apply(2'b10, 0, 0, 2'b00, 0, 2'b00, 0, 2'b00, 8'hF0, 8'h3C, 1, 0, "R2");
    apply(2'b10, 0, 0, 2'b01, 0, 2'b00, 0, 2'b00, 8'hF0, 8'h3C, 1, 0, "R2");
    apply(2'b10, 0, 0, 2'b11, 0, 2'b00, 0, 2'b00, 8'h5A, 8'h5A, 1, 0, "R9");
    apply(2'b11, 0, 0, 2'b00, 0, 2'b00, 0, 2'b00, 8'hFF, 8'h01, 0, 0, "R3");
    apply(2'b11, 0, 1, 2'b00, 0, 2'b00, 0, 2'b00, 8'hFE, 8'h01, 1, 0, "R3");
    apply(2'b11, 0, 0, 2'b00, 0, 2'b00, 0, 2'b00, 8'h10, 8'h20, 1, 0, "R10");
    apply(2'b11, 1, 0, 2'b00, 0, 2'b00, 0, 2'b00, 8'h30, 8'h30, 1, 0, "R10");
    apply(2'b11, 1, 1, 2'b00, 0, 2'b00, 0, 2'b00, 8'h30, 8'h30, 1, 1, "R4");
    apply(2'b11, 1, 0, 2'b00, 0, 2'b00, 0, 2'b00, 8'h05, 8'h06, 0, 0, "R4");
    apply(2'b01, 0, 0, 2'b00, 0, 2'b00, 1, 2'b00, 8'h81, 8'h00, 0, 0, "R5");
    apply(2'b01, 0, 0, 2'b00, 0, 2'b01, 0, 2'b00, 8'h40, 8'h00, 1, 0, "R7");
    apply(2'b01, 0, 0, 2'b00, 0, 2'b10, 0, 2'b00, 8'h80, 8'h00, 0, 0, "R7");
    apply(2'b01, 0, 0, 2'b00, 0, 2'b11, 0, 2'b00, 8'h01, 8'h00, 0, 0, "R7");
    apply(2'b01, 0, 0, 2'b00, 1, 2'b00, 0, 2'b00, 8'h01, 8'h00, 1, 0, "R6");
    apply(2'b01, 0, 0, 2'b00, 1, 2'b10, 0, 2'b00, 8'h01, 8'h00, 0, 0, "R7");
    apply(2'b01, 0, 0, 2'b00, 1, 2'b11, 0, 2'b00, 8'h80, 8'h00, 0, 0, "R7");
    apply(2'b01, 0, 0, 2'b00, 1, 2'b01, 0, 2'b00, 8'h02, 8'h00, 1, 0, "R7");
    apply(2'b11, 0, 0, 2'b00, 0, 2'b00, 0, 2'b01, 8'hFF, 8'h01, 0, 0, "R8");
    apply(2'b10, 0, 0, 2'b00, 0, 2'b00, 0, 2'b11, 8'h00, 8'h00, 0, 0, "R8");
    apply(2'b11, 0, 0, 2'b00, 0, 2'b00, 0, 2'b10, 8'hFF, 8'h01, 1, 0, "R8");

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      @(posedge clk);
      opType = 2'($urandom); arithSub = 1'($urandom); arithUseCarry = 1'($urandom);
      logicSel = 2'($urandom); shiftRight = 1'($urandom); insertSrc = 2'($urandom);
      insertConst = 1'($urandom); carryMode = 2'($urandom);
      opA = 8'($urandom); opB = 8'($urandom);
      if (($urandom % 8) == 0) opB = opA;
      carryIn = 1'($urandom); zeroIn = 1'($urandom);
      @(negedge clk);
      check(tag_of());
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule